// File: doc/BRIEF.md
# Saturating Split-Lane Accumulator ALU

This block is an accumulator arithmetic unit whose datapath can run as one wide signed word or be split into independent lanes. Each operation takes the accumulator operand A and a second operand B. It then adds, subtracts, or multiplies B by a coefficient and adds the product to A. The result is registered together with carry, overflow, negative and zero flags. An internal extension bit supplies a carry-in for chained multi-word arithmetic. Results that leave the representable range clamp to the nearest limit instead of wrapping.

Three lane layouts are selected per operation. In scalar mode the whole word is one signed lane. In stereo mode it is two signed halves. In pixel mode it is three (16-bit word) or four (32/64-bit word) unsigned lanes packed from bit 0 upward. In a multiply-accumulate, one coefficient is used by every lane. It is the low lane-width bits of the coefficient input.

Top module: `sat_lane_alu`

## Requirements
- R1: While reset is high and on the first cycle after it, result is 0, flag_z is 1, and flag_c, flag_v, flag_n and flag_x are 0.
- R2: op encodes 0=add, 1=subtract, 2=multiply-accumulate, 3=set-extension. For an arithmetic op accepted with valid=1, result holds A+B+X (add) or A-B-X (subtract) from the next clock edge. Scalar mode (mode=0) treats the whole word as signed.
- R3: In a signed lane, a true result above the lane maximum gives the lane maximum. A true result below the lane minimum gives the lane minimum. In either case flag_v is 1.
- R4: Stereo mode (mode=1) computes two signed lanes of DATA_W/2 bits independently. Lane i sits at bits [i*DATA_W/2 +: DATA_W/2], and each lane saturates by itself.
- R5: Pixel mode (mode=2) computes unsigned lanes (4 lanes of DATA_W/4 bits; 3 lanes of 5 bits when DATA_W=16). Lane i sits at bits [i*W +: W]. Each lane clamps independently to its all-ones maximum or to 0. Any result bits above the top lane are 0.
- R6: Multiply-accumulate adds to each lane of A the product of the matching lane of B and the low lane-width bits of coef, plus X. The product is truncated to lane width before the addition, and every lane uses the same coefficient.
- R7: Set-extension copies the current flag_c into flag_x and leaves result and the other flags unchanged. Every arithmetic op clears flag_x. The flag_x value at the time of an arithmetic op is added as carry-in to every lane, and subtracted as borrow for a subtract.
- R8: flag_c is the unsigned carry out of the most significant lane: carry for add and multiply-accumulate, borrow for subtract. flag_v is 1 when any lane saturated.
- R9: flag_n equals the most significant bit of result, and flag_z is 1 exactly when result is 0.
- R10: When valid is 0, result and all flags keep their values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid | input | 1 | Accept the operation this cycle |
| op | input | 2 | Operation code |
| mode | input | 2 | Lane layout: 0 scalar, 1 stereo, 2 pixel (3 acts as scalar) |
| a | input | DATA_W | Accumulator operand |
| b | input | DATA_W | Second operand |
| coef | input | DATA_W | Shared multiply coefficient (low lane-width bits used) |
| result | output | DATA_W | Registered result |
| flag_c | output | 1 | Carry / borrow of the top lane |
| flag_v | output | 1 | Saturation occurred |
| flag_n | output | 1 | Sign bit of result |
| flag_z | output | 1 | Result is zero |
| flag_x | output | 1 | Extension carry-in bit |

## Verification
Some properties are checked on every cycle: that result and flags hold while valid is low, and that flag_n and flag_z agree with the registered result. The extension bit is also checked each cycle, for clearing after arithmetic and for copying carry on set-extension. A saturated scalar result must land on one of the two signed limits. The per-lane values are another matter: independent lane clamping in stereo and pixel layouts, truncation of the shared-coefficient product, and the top-lane carry can only be shown by the bench's scenarios. It runs them through a lane-by-lane reference model, using directed boundary operands followed by a long random mix.

// File: rtl/sat_lane_alu_pkg.sv
package sat_lane_alu_pkg;

    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_SUB  = 2'd1,
        OP_MAC  = 2'd2,
        OP_SETX = 2'd3
    } salu_op_e;

    typedef enum logic [1:0] {
        MD_SCALAR = 2'd0,
        MD_STEREO = 2'd1,
        MD_PIXEL  = 2'd2,
        MD_RSVD   = 2'd3
    } salu_mode_e;

    typedef struct packed {
        logic c;
        logic v;
        logic n;
        logic z;
    } salu_flags_t;

    // Pixel lane count: three on a 16-bit word, four otherwise.
    function automatic int pix_lanes(input int width);
        return (width == 16) ? 3 : 4;
    endfunction

endpackage

// File: rtl/salu_lane.sv
module salu_lane
    import sat_lane_alu_pkg::*;
#(
    parameter int LW = 16
) (
    input  logic [LW-1:0] a,
    input  logic [LW-1:0] b,
    input  logic [LW-1:0] coef,
    input  salu_op_e      op,
    input  logic          is_signed,
    input  logic          x,
    output logic [LW-1:0] res,
    output logic          carry,
    output logic          sat
);
    localparam int EW = LW + 2;

    logic [LW-1:0] prod;
    logic [LW-1:0] term;
    logic [LW:0]   uraw;
    logic [EW-1:0] sraw;
    logic [EW-1:0] sa;
    logic [EW-1:0] st;
    logic          s_ovf;

    // product truncated to lane width (low bits equal for signed and unsigned)
    assign prod = b * coef;
    assign term = (op == OP_MAC) ? prod : b;

    assign sa = {a[LW-1], a[LW-1], a};
    assign st = {term[LW-1], term[LW-1], term};

    always_comb begin
        if (op == OP_SUB) begin
            uraw = {1'b0, a} - {1'b0, term} - {{LW{1'b0}}, x};
            sraw = sa - st - {{(EW-1){1'b0}}, x};
        end else begin
            uraw = {1'b0, a} + {1'b0, term} + {{LW{1'b0}}, x};
            sraw = sa + st + {{(EW-1){1'b0}}, x};
        end
    end

    assign s_ovf = (sraw[EW-1] != sraw[LW-1]) || (sraw[EW-1] != sraw[LW]);
    assign carry = uraw[LW];

    always_comb begin
        if (is_signed) begin
            sat = s_ovf;
            if (s_ovf)
                res = sraw[EW-1] ? {1'b1, {(LW-1){1'b0}}} : {1'b0, {(LW-1){1'b1}}};
            else
                res = sraw[LW-1:0];
        end else begin
            sat = uraw[LW];
            if (uraw[LW])
                res = (op == OP_SUB) ? {LW{1'b0}} : {LW{1'b1}};
            else
                res = uraw[LW-1:0];
        end
    end

endmodule

// File: rtl/sat_lane_alu.sv
module sat_lane_alu
    import sat_lane_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  logic [1:0]        op,
    input  logic [1:0]        mode,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [DATA_W-1:0] coef,
    output logic [DATA_W-1:0] result,
    output logic              flag_c,
    output logic              flag_v,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_x
);
    localparam int ST_N  = 2;
    localparam int ST_W  = DATA_W / ST_N;
    localparam int PX_N  = pix_lanes(DATA_W);
    localparam int PX_W  = DATA_W / PX_N;
    localparam int PX_USED = PX_N * PX_W;
    localparam logic [DATA_W-1:0] S_MAX = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] S_MIN = {1'b1, {(DATA_W-1){1'b0}}};

    salu_op_e    op_e;
    salu_mode_e  mode_e;
    assign op_e   = salu_op_e'(op);
    assign mode_e = salu_mode_e'(mode);

    logic [DATA_W-1:0] res_q;
    salu_flags_t       flg_q;
    logic              x_q;

    // scalar lane
    logic [DATA_W-1:0] sc_res;
    logic              sc_c, sc_sat;

    salu_lane #(.LW(DATA_W)) u_scalar (
        .a(a), .b(b), .coef(coef), .op(op_e), .is_signed(1'b1), .x(x_q),
        .res(sc_res), .carry(sc_c), .sat(sc_sat)
    );

    // stereo lanes
    logic [DATA_W-1:0] st_res;
    logic [ST_N-1:0]   st_c, st_sat;

    for (genvar g = 0; g < ST_N; g++) begin : g_stereo
        salu_lane #(.LW(ST_W)) u_lane (
            .a(a[g*ST_W +: ST_W]), .b(b[g*ST_W +: ST_W]), .coef(coef[ST_W-1:0]),
            .op(op_e), .is_signed(1'b1), .x(x_q),
            .res(st_res[g*ST_W +: ST_W]), .carry(st_c[g]), .sat(st_sat[g])
        );
    end

    // pixel lanes
    logic [DATA_W-1:0] px_res;
    logic [PX_N-1:0]   px_c, px_sat;

    for (genvar g = 0; g < PX_N; g++) begin : g_pixel
        salu_lane #(.LW(PX_W)) u_lane (
            .a(a[g*PX_W +: PX_W]), .b(b[g*PX_W +: PX_W]), .coef(coef[PX_W-1:0]),
            .op(op_e), .is_signed(1'b0), .x(x_q),
            .res(px_res[g*PX_W +: PX_W]), .carry(px_c[g]), .sat(px_sat[g])
        );
    end

    if (PX_USED < DATA_W) begin : g_px_pad
        assign px_res[DATA_W-1:PX_USED] = '0;
    end

    // lane layout select
    logic [DATA_W-1:0] nxt_res;
    salu_flags_t       nxt_flg;

    always_comb begin
        case (mode_e)
            MD_STEREO: begin
                nxt_res   = st_res;
                nxt_flg.c = st_c[ST_N-1];
                nxt_flg.v = |st_sat;
            end
            MD_PIXEL: begin
                nxt_res   = px_res;
                nxt_flg.c = px_c[PX_N-1];
                nxt_flg.v = |px_sat;
            end
            default: begin
                nxt_res   = sc_res;
                nxt_flg.c = sc_c;
                nxt_flg.v = sc_sat;
            end
        endcase
        nxt_flg.n = nxt_res[DATA_W-1];
        nxt_flg.z = (nxt_res == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            flg_q <= '{c: 1'b0, v: 1'b0, n: 1'b0, z: 1'b1};
            x_q   <= 1'b0;
        end else if (valid) begin
            if (op_e == OP_SETX) begin
                x_q <= flg_q.c;
            end else begin
                res_q <= nxt_res;
                flg_q <= nxt_flg;
                x_q   <= 1'b0;
            end
        end
    end

    assign result = res_q;
    assign flag_c = flg_q.c;
    assign flag_v = flg_q.v;
    assign flag_n = flg_q.n;
    assign flag_z = flg_q.z;
    assign flag_x = x_q;

    // R10
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !valid |=> ($stable(result) && $stable(flag_c) && $stable(flag_v)
                    && $stable(flag_n) && $stable(flag_z) && $stable(flag_x)));

    // R7
    x_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && op != 2'd3) |=> !flag_x);

    // R7
    setx_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && op == 2'd3) |=> (flag_x == $past(flag_c)) && $stable(result));

    // R9
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        flag_z == (result == '0));

    // R9
    neg_flag_chk: assert property (@(posedge clk) disable iff (rst)
        flag_n == result[DATA_W-1]);

    // R3
    scalar_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && op != 2'd3 && mode == 2'd0) |=>
            (!flag_v || result == S_MAX || result == S_MIN));

endmodule

// File: tb/sat_lane_alu_tb_top.sv
`timescale 1ns/1ps
module sat_lane_alu_tb_top;

    localparam int W = 32;

    typedef struct {
        logic [W-1:0] res;
        bit c, v, n, z, x;
        string tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         valid = 1'b0;
    logic [1:0]   op = 2'd0;
    logic [1:0]   mode = 2'd0;
    logic [W-1:0] a = '0, b = '0, coef = '0;
    logic [W-1:0] result;
    logic         flag_c, flag_v, flag_n, flag_z, flag_x;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    exp_t exp_q[$];
    logic vld_q = 1'b0;

    // bench reference state
    logic [W-1:0] m_res = '0;
    bit m_c = 0, m_v = 0, m_n = 0, m_z = 1, m_x = 0;

    always #2.5 clk = ~clk;

    sat_lane_alu #(.DATA_W(W)) dut_i (
        .clk(clk), .rst(rst), .valid(valid), .op(op), .mode(mode),
        .a(a), .b(b), .coef(coef), .result(result),
        .flag_c(flag_c), .flag_v(flag_v), .flag_n(flag_n),
        .flag_z(flag_z), .flag_x(flag_x)
    );

    function automatic void model(input int o, input int md, input logic [W-1:0] ia,
                                  input logic [W-1:0] ib, input logic [W-1:0] ic,
                                  input bit xi, output logic [W-1:0] r,
                                  output bit c, output bit v);
        int nl, lw;
        bit sgn;
        r = '0; c = 0; v = 0;
        if (md == 1) begin nl = 2; lw = 16; sgn = 1; end
        else if (md == 2) begin nl = 4; lw = 8; sgn = 0; end
        else begin nl = 1; lw = 32; sgn = 1; end
        for (int i = 0; i < nl; i++) begin
            longint mask, ua, ub, uc, t, u, sa, st, raw, lo, hi, rl;
            mask = (longint'(1) << lw) - 1;
            ua = (longint'(ia) >> (i*lw)) & mask;
            ub = (longint'(ib) >> (i*lw)) & mask;
            uc = longint'(ic) & mask;
            t  = (o == 2) ? ((ub * uc) & mask) : ub;
            u  = (o == 1) ? (ua - t - xi) : (ua + t + xi);
            c  = ((u >> lw) & 1) != 0;
            if (sgn) begin
                hi = (longint'(1) << (lw-1)) - 1;
                lo = -(longint'(1) << (lw-1));
                sa = (ua > hi) ? ua - (mask + 1) : ua;
                st = (t > hi) ? t - (mask + 1) : t;
                raw = (o == 1) ? (sa - st - xi) : (sa + st + xi);
                if (raw > hi) begin rl = hi; v = 1; end
                else if (raw < lo) begin rl = lo; v = 1; end
                else rl = raw;
            end else begin
                if (u > mask) begin rl = mask; v = 1; end
                else if (u < 0) begin rl = 0; v = 1; end
                else rl = u;
            end
            r = r | W'((rl & mask) << (i*lw));
        end
    endfunction

    task automatic drive(input int o, input int md, input logic [W-1:0] ia,
                         input logic [W-1:0] ib, input logic [W-1:0] ic, input string tag);
        exp_t e;
        logic [W-1:0] r;
        bit c, v;
        @(negedge clk);
        valid = 1'b1; op = 2'(o); mode = 2'(md); a = ia; b = ib; coef = ic;
        if (o == 3) begin
            m_x = m_c;
        end else begin
            model(o, md, ia, ib, ic, m_x, r, c, v);
            m_res = r; m_c = c; m_v = v; m_n = r[W-1]; m_z = (r == '0); m_x = 0;
        end
        e.res = m_res; e.c = m_c; e.v = m_v; e.n = m_n; e.z = m_z; e.x = m_x; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic cmp(input string tag, input logic [W-1:0] act_r, input bit ac, av, an, az, ax,
                       input logic [W-1:0] exp_r, input bit ec, ev, en, ez, ex);
        checks++;
        if (act_r !== exp_r || ac !== ec || av !== ev || an !== en || az !== ez || ax !== ex) begin
            failures++;
            $display("FAIL %s: act res=%h c%0d v%0d n%0d z%0d x%0d exp res=%h c%0d v%0d n%0d z%0d x%0d",
                     tag, act_r, ac, av, an, az, ax, exp_r, ec, ev, en, ez, ex);
        end
    endtask

    always @(posedge clk) vld_q <= valid && !rst;

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (vld_q) begin
                exp_t e;
                if (exp_q.size() == 0) begin
                    checks++; failures++;
                    $display("FAIL scoreboard: act result with empty queue exp none");
                end else begin
                    e = exp_q.pop_front();
                    cmp(e.tag, result, flag_c, flag_v, flag_n, flag_z, flag_x,
                        e.res, e.c, e.v, e.n, e.z, e.x);
                end
            end
        end
    end

    // watchdog
    initial begin
        #(5ns * 100000);
        if (!finished) begin
            finished = 1;
            checks++; failures++;
            $display("FAIL watchdog: act hung exp completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset values during reset
        cmp("R1 in reset", result, flag_c, flag_v, flag_n, flag_z, flag_x, '0, 0, 0, 0, 1, 0);
        rst = 1'b0;
        @(negedge clk);
        cmp("R1 after reset", result, flag_c, flag_v, flag_n, flag_z, flag_x, '0, 0, 0, 0, 1, 0);

        drive(0, 0, 32'd5, 32'd7, '0, "R2 add");
        drive(1, 0, 32'd3, 32'd10, '0, "R2 sub negative");
        drive(3, 0, 32'd99, 32'd99, '0, "R7 setx copies borrow");
        drive(0, 0, 32'd1, 32'd1, '0, "R7 add with X carry-in");
        drive(1, 0, 32'd5, 32'd5, '0, "R9 zero result");
        drive(0, 0, 32'h7FFF_FFFF, 32'd1, '0, "R3 positive clamp");
        drive(1, 0, 32'h8000_0000, 32'd1, '0, "R3 negative clamp");
        drive(0, 0, 32'hFFFF_FFFF, 32'd1, '0, "R8 carry top lane");
        drive(0, 1, 32'h7FF0_0005, 32'h0020_FFFE, '0, "R4 stereo lane clamp");
        drive(1, 1, 32'h8005_0010, 32'h0010_0020, '0, "R4 stereo negative");
        drive(0, 2, 32'hF010_8001, 32'h2010_9001, '0, "R5 pixel add clamp");
        drive(1, 2, 32'h1050_0230, 32'h2010_0340, '0, "R5 pixel sub clamp");
        drive(2, 0, 32'd100, 32'hFFFF_FFFD, 32'd7, "R6 scalar mac");
        drive(2, 1, 32'h0010_0020, 32'h0003_FFFF, 32'h0000_0005, "R6 stereo shared coef");
        drive(2, 2, 32'h0102_0304, 32'h4001_0203, 32'hFFFF_FF04, "R6 pixel truncation");
        drive(1, 0, 32'd0, 32'd1, '0, "R8 borrow");
        drive(3, 2, '0, '0, '0, "R7 setx");
        drive(0, 2, 32'hFF00_0000, 32'h0100_0000, '0, "R7 pixel X lanes");
        idle(1);

        // R10 inputs change while valid is low
        a = 32'h1234_5678; b = 32'h7654_3210; op = 2'd3; mode = 2'd2;
        repeat (3) @(negedge clk);
        cmp("R10 hold", result, flag_c, flag_v, flag_n, flag_z, flag_x,
            m_res, m_c, m_v, m_n, m_z, m_x);

        for (int k = 0; k < 300; k++) begin
            int o, md;
            o = $urandom_range(0, 3);
            md = $urandom_range(0, 3);
            drive(o, md, $urandom, $urandom, $urandom, "R8 random mix");
            if (k % 37 == 0) idle(2);
        end
        idle(4);

        if (exp_q.size() != 0) begin
            checks++; failures++;
            $display("FAIL scoreboard drain: act %0d left exp 0", exp_q.size());
        end
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule